// File: doc/BRIEF.md
# SD Host Interrupt Status Unit

This block gathers the completion and error events that the command and data engines of an SD/MMC host raise, and latches them into two byte-wide sticky status registers. Software clears a latched event by writing a 1 to its bit. A per-bit enable mask sits beside each status byte. The single level-sensitive interrupt line is the OR of every enabled, latched event, gated by a global enable bit.

The unit also watches the card pins. The write-protect pin and two card-detect pins (a DAT3-based one and a dedicated detect pin) pass through a two-flop synchronizer, and their levels appear live in the first status byte. A configuration word selects which card-detect pin is watched and at which polarity. A change of the selected, polarity-corrected level latches a change event. A move to the active level also latches an insertion event. The same configuration word holds the block length and the abort-on-CRC-error flag, which go out to the data engine.

Access is through a byte-addressed register port with a write strobe and a combinational read path. A soft-reset command zeroes all status and mask bits and keeps the configuration word.

Top module: `sdh_irq_status`

## Requirements
- R1: After reset every status, mask and configuration byte reads 0x00, `irq_o` is low, and `blk_len_m1_o` and `crc_abort_o` are zero.
- R2: A one-cycle pulse on `evt_cmd_i[n]` sets bit n of status byte B (address 1): bit 0 SDIO interrupt, bit 1 command done, bit 2 response timeout, bit 3 auto-stop done, bit 4 data timeout, bit 5 response CRC error, bit 6 read CRC error, bit 7 write CRC error.
- R3: Latched status bits stay set until software writes 1 to them at their status address. Written 0 bits are left unchanged, and 0xFF clears every latched bit of the byte.
- R4: When an event and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R5: In status byte A (address 0), a pulse on `evt_mblk_done_i` sets bit 4 and a pulse on `evt_blk_done_i` sets bit 5. Bit 0 always reads 0.
- R6: `irq_o` is high exactly when configuration bit 15 (address 5, bit 7) is set and some latched status bit has its mask bit set. Mask A is at address 2 with bits 7..4 implemented. Mask B is at address 3 with bits 7..1 implemented. Unimplemented mask bits read 0, so SDIO (B bit 0) never raises the line.
- R7: Writing address 6 with bit 7 set zeroes both status bytes and both masks in the next cycle, overriding events in that same cycle. The configuration word is kept. Writing address 6 with bit 7 clear has no effect.
- R8: Status A bit 1 shows the write-protect pin, bit 2 the DAT3 detect pin and bit 3 the detect pin, each two clocks after the pin changes. Writing 1 to these bits does not alter them.
- R9: Configuration bit 14 (address 5, bit 6) selects DAT3 and bit 13 (address 5, bit 5) selects the detect pin. DAT3 wins if both are set, and with neither set no card events occur. Bit 12 (address 5, bit 4) set means the active level is high. Any change of the selected, polarity-corrected level sets status A bit 6, and a change to the active level also sets bit 7. Neither is set in a cycle where the select or polarity fields changed.
- R10: The configuration word reads back as bits 7..0 at address 4 and bits 15..8 at address 5. `blk_len_m1_o` carries bits 10..0 and `crc_abort_o` carries bit 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register byte address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for `reg_addr_i` |
| evt_mblk_done_i | input | 1 | Multi-block transfer done strobe |
| evt_blk_done_i | input | 1 | Single block done strobe |
| evt_cmd_i | input | 8 | Command and data engine event strobes, one per status B bit |
| pin_wp_i | input | 1 | Write-protect pin, asynchronous |
| pin_dat3_i | input | 1 | DAT3 card-detect pin, asynchronous |
| pin_gpi_i | input | 1 | Dedicated card-detect pin, asynchronous |
| irq_o | output | 1 | Level interrupt request |
| blk_len_m1_o | output | 11 | Block length minus one |
| crc_abort_o | output | 1 | Abort on CRC error flag |

## Verification
On every cycle the assertions check the rules of the sticky registers: a latched bit survives any cycle without a matching clear or soft reset, an event beats a concurrent clear, and a soft reset empties status and masks, drops the interrupt and leaves the configuration alone. Only the bench scenarios can show what the pin path does: the two-clock delay of the live levels, source priority and polarity, which of the change and insertion bits an edge sets, and that rewriting the detect fields creates no spurious event. The bench also covers the bit layout of each status byte and the masking and global gating of the interrupt.

// File: rtl/sdh_irq_pkg.sv
package sdh_irq_pkg;

    localparam int STAT_W = 8;
    localparam int CFG_W  = 2 * STAT_W;
    localparam int REG_AW = 3;

    // register byte addresses
    localparam logic [REG_AW-1:0] ADR_STAT_A = 3'd0;
    localparam logic [REG_AW-1:0] ADR_STAT_B = 3'd1;
    localparam logic [REG_AW-1:0] ADR_MASK_A = 3'd2;
    localparam logic [REG_AW-1:0] ADR_MASK_B = 3'd3;
    localparam logic [REG_AW-1:0] ADR_CFG_LO = 3'd4;
    localparam logic [REG_AW-1:0] ADR_CFG_HI = 3'd5;
    localparam logic [REG_AW-1:0] ADR_CTRL   = 3'd6;

    // implemented bits
    localparam logic [STAT_W-1:0] STICKY_A_IMPL = 8'hF0;
    localparam logic [STAT_W-1:0] STICKY_B_IMPL = 8'hFF;
    localparam logic [STAT_W-1:0] MASK_A_IMPL   = 8'hF0;
    localparam logic [STAT_W-1:0] MASK_B_IMPL   = 8'hFE;

    // configuration word bit positions
    localparam int CFG_GIE      = 15;
    localparam int CFG_SEL_DAT3 = 14;
    localparam int CFG_SEL_GPI  = 13;
    localparam int CFG_POL_HIGH = 12;
    localparam int CFG_CRC_ABRT = 11;

    // control byte
    localparam int CTRL_SRST = 7;

    typedef struct packed {
        logic [STAT_W-1:0] mask_a;
        logic [STAT_W-1:0] mask_b;
        logic [CFG_W-1:0]  cfg;
    } sdh_ctl_t;

endpackage

// File: rtl/sdh_pin_sync.sv
module sdh_pin_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] sync_o
);
    localparam int CHAIN_W = N * STAGES;

    typedef struct packed {
        logic [CHAIN_W-1:0] chain;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[CHAIN_W-N-1:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.chain[CHAIN_W-1 -: N];

endmodule

// File: rtl/sdh_cd_detect.sv
module sdh_cd_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic dat3_s_i,
    input  logic gpi_s_i,
    input  logic sel_dat3_i,
    input  logic sel_gpi_i,
    input  logic pol_high_i,
    output logic chg_o,
    output logic ins_o
);
    typedef struct packed {
        logic       det_prev;
        logic [2:0] cfg_prev;
    } cd_st_t;

    cd_st_t     st_d, st_q;
    logic       have_src;
    logic       raw;
    logic       det;
    logic [2:0] cfg_now;

    always_comb begin
        have_src = sel_dat3_i | sel_gpi_i;
        raw      = sel_dat3_i ? dat3_s_i : gpi_s_i;
        det      = have_src & (pol_high_i ? raw : ~raw);
        cfg_now  = {sel_dat3_i, sel_gpi_i, pol_high_i};

        chg_o    = have_src && (det != st_q.det_prev) && (cfg_now == st_q.cfg_prev);
        ins_o    = chg_o && det;

        st_d          = st_q;
        st_d.det_prev = det;
        st_d.cfg_prev = cfg_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/sdh_sticky_byte.sv
module sdh_sticky_byte #(
    parameter int           W    = 8,
    parameter logic [W-1:0] IMPL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         srst_i,
    input  logic         clr_we_i,
    input  logic [W-1:0] clr_bits_i,
    input  logic [W-1:0] set_i,
    output logic [W-1:0] q_o
);
    typedef struct packed {
        logic [W-1:0] bits;
    } stk_st_t;

    stk_st_t      st_d, st_q;
    logic [W-1:0] after_clr;

    always_comb begin
        st_d      = st_q;
        after_clr = clr_we_i ? (st_q.bits & ~clr_bits_i) : st_q.bits;
        if (srst_i) st_d.bits = '0;
        else        st_d.bits = (after_clr | set_i) & IMPL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_o = st_q.bits;

    // soft reset empties the byte (R7)
    p_srst_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        srst_i |=> (q_o == '0));

    for (genvar i = 0; i < W; i++) begin : g_chk
        if (IMPL[i]) begin : g_impl
            // latched bit survives when nothing clears it (R3)
            p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (q_o[i] && !srst_i && !(clr_we_i && clr_bits_i[i])) |=> q_o[i]);
            // an event beats a concurrent clear (R4)
            p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (set_i[i] && !srst_i) |=> q_o[i]);
        end
    end

endmodule

// File: rtl/sdh_irq_status.sv
module sdh_irq_status
    import sdh_irq_pkg::*;
#(
    parameter int BLK_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_i,
    input  logic [REG_AW-1:0] reg_addr_i,
    input  logic [STAT_W-1:0] reg_wdata_i,
    output logic [STAT_W-1:0] reg_rdata_o,
    input  logic              evt_mblk_done_i,
    input  logic              evt_blk_done_i,
    input  logic [STAT_W-1:0] evt_cmd_i,
    input  logic              pin_wp_i,
    input  logic              pin_dat3_i,
    input  logic              pin_gpi_i,
    output logic              irq_o,
    output logic [BLK_W-1:0]  blk_len_m1_o,
    output logic              crc_abort_o
);
    localparam int NPIN = 3;

    sdh_ctl_t ctl_d, ctl_q;

    logic              wr_stat_a, wr_stat_b;
    logic              srst;
    logic [NPIN-1:0]   pins_s;
    logic              wp_s, dat3_s, gpi_s;
    logic              cd_chg, cd_ins;
    logic [STAT_W-1:0] set_a;
    logic [STAT_W-1:0] stat_a_q, stat_b_q;
    logic [STAT_W-1:0] stat_a_view;

    // ---------------- write decode ----------------
    always_comb begin
        wr_stat_a = reg_wr_i && (reg_addr_i == ADR_STAT_A);
        wr_stat_b = reg_wr_i && (reg_addr_i == ADR_STAT_B);
        srst      = reg_wr_i && (reg_addr_i == ADR_CTRL) && reg_wdata_i[CTRL_SRST];
    end

    // ---------------- masks and configuration ----------------
    always_comb begin
        ctl_d = ctl_q;
        if (srst) begin
            ctl_d.mask_a = '0;
            ctl_d.mask_b = '0;
        end else if (reg_wr_i) begin
            unique case (reg_addr_i)
                ADR_MASK_A: ctl_d.mask_a = reg_wdata_i & MASK_A_IMPL;
                ADR_MASK_B: ctl_d.mask_b = reg_wdata_i & MASK_B_IMPL;
                ADR_CFG_LO: ctl_d.cfg[STAT_W-1:0] = reg_wdata_i;
                ADR_CFG_HI: ctl_d.cfg[CFG_W-1:STAT_W] = reg_wdata_i;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    // ---------------- pin path ----------------
    sdh_pin_sync #(
        .N      (NPIN),
        .STAGES (2)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({pin_gpi_i, pin_dat3_i, pin_wp_i}),
        .sync_o  (pins_s)
    );

    assign {gpi_s, dat3_s, wp_s} = pins_s;

    sdh_cd_detect u_cd (
        .clk        (clk),
        .rst_n      (rst_n),
        .dat3_s_i   (dat3_s),
        .gpi_s_i    (gpi_s),
        .sel_dat3_i (ctl_q.cfg[CFG_SEL_DAT3]),
        .sel_gpi_i  (ctl_q.cfg[CFG_SEL_GPI]),
        .pol_high_i (ctl_q.cfg[CFG_POL_HIGH]),
        .chg_o      (cd_chg),
        .ins_o      (cd_ins)
    );

    // ---------------- sticky status ----------------
    assign set_a = {cd_ins, cd_chg, evt_blk_done_i, evt_mblk_done_i, 4'b0000};

    sdh_sticky_byte #(
        .W    (STAT_W),
        .IMPL (STICKY_A_IMPL)
    ) u_stat_a (
        .clk        (clk),
        .rst_n      (rst_n),
        .srst_i     (srst),
        .clr_we_i   (wr_stat_a),
        .clr_bits_i (reg_wdata_i),
        .set_i      (set_a),
        .q_o        (stat_a_q)
    );

    sdh_sticky_byte #(
        .W    (STAT_W),
        .IMPL (STICKY_B_IMPL)
    ) u_stat_b (
        .clk        (clk),
        .rst_n      (rst_n),
        .srst_i     (srst),
        .clr_we_i   (wr_stat_b),
        .clr_bits_i (reg_wdata_i),
        .set_i      (evt_cmd_i),
        .q_o        (stat_b_q)
    );

    assign stat_a_view = stat_a_q | {4'b0000, gpi_s, dat3_s, wp_s, 1'b0};

    // ---------------- interrupt and outputs ----------------
    always_comb begin
        irq_o = ctl_q.cfg[CFG_GIE] &
                (|((stat_a_q & ctl_q.mask_a) | (stat_b_q & ctl_q.mask_b)));
    end

    assign blk_len_m1_o = ctl_q.cfg[BLK_W-1:0];
    assign crc_abort_o  = ctl_q.cfg[CFG_CRC_ABRT];

    always_comb begin
        unique case (reg_addr_i)
            ADR_STAT_A: reg_rdata_o = stat_a_view;
            ADR_STAT_B: reg_rdata_o = stat_b_q;
            ADR_MASK_A: reg_rdata_o = ctl_q.mask_a;
            ADR_MASK_B: reg_rdata_o = ctl_q.mask_b;
            ADR_CFG_LO: reg_rdata_o = ctl_q.cfg[STAT_W-1:0];
            ADR_CFG_HI: reg_rdata_o = ctl_q.cfg[CFG_W-1:STAT_W];
            default:    reg_rdata_o = '0;
        endcase
    end

    // ---------------- assertions ----------------
    // soft reset zeroes both masks (R7)
    p_mask_srst_r7: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (ctl_q.mask_a == '0 && ctl_q.mask_b == '0));
    // soft reset keeps the configuration word (R7)
    p_cfg_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> $stable(ctl_q.cfg));
    // interrupt is quiet right after a soft reset (R6)
    p_irq_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> !irq_o);

endmodule

// File: tb/sim_sdh_irq_status.sv
`timescale 1ns/1ps
module sim_sdh_irq_status;
    import sdh_irq_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr_i = 1'b0;
    logic [REG_AW-1:0] reg_addr_i = '0;
    logic [7:0]        reg_wdata_i = '0;
    logic [7:0]        reg_rdata_o;
    logic              evt_mblk_done_i = 1'b0;
    logic              evt_blk_done_i = 1'b0;
    logic [7:0]        evt_cmd_i = '0;
    logic              pin_wp_i = 1'b0;
    logic              pin_dat3_i = 1'b0;
    logic              pin_gpi_i = 1'b0;
    logic              irq_o;
    logic [10:0]       blk_len_m1_o;
    logic              crc_abort_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    sdh_irq_status u0 (
        .clk             (clk),
        .rst_n           (rst_n),
        .reg_wr_i        (reg_wr_i),
        .reg_addr_i      (reg_addr_i),
        .reg_wdata_i     (reg_wdata_i),
        .reg_rdata_o     (reg_rdata_o),
        .evt_mblk_done_i (evt_mblk_done_i),
        .evt_blk_done_i  (evt_blk_done_i),
        .evt_cmd_i       (evt_cmd_i),
        .pin_wp_i        (pin_wp_i),
        .pin_dat3_i      (pin_dat3_i),
        .pin_gpi_i       (pin_gpi_i),
        .irq_o           (irq_o),
        .blk_len_m1_o    (blk_len_m1_o),
        .crc_abort_o     (crc_abort_o)
    );

    typedef struct packed {
        logic       wr;
        logic [7:0] wdata;
        logic [7:0] ev;
        logic [7:0] exp_b;
        logic       exp_irq;
    } vec_t;

    localparam int NVEC = 10;
    // status B walk with mask B = 0xFE and global enable on
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 8'h00, 8'h02, 8'h02, 1'b1},
        '{1'b0, 8'h00, 8'h01, 8'h03, 1'b1},
        '{1'b1, 8'h02, 8'h00, 8'h01, 1'b0},
        '{1'b1, 8'h00, 8'h80, 8'h81, 1'b1},
        '{1'b1, 8'h80, 8'h80, 8'h81, 1'b1},
        '{1'b1, 8'hFF, 8'h00, 8'h00, 1'b0},
        '{1'b0, 8'h00, 8'h3C, 8'h3C, 1'b1},
        '{1'b1, 8'h0C, 8'h00, 8'h30, 1'b1},
        '{1'b1, 8'h30, 8'h40, 8'h40, 1'b1},
        '{1'b1, 8'hFF, 8'h00, 8'h00, 1'b0}
    };

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [REG_AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
        @(negedge clk);
        reg_wr_i = 1'b0;
    endtask

    task automatic chk_reg(input string tag, input logic [REG_AW-1:0] a, input logic [7:0] exp);
        @(negedge clk);
        reg_addr_i = a;
        #1;
        check(tag, reg_rdata_o, exp);
    endtask

    task automatic pulse_b(input logic [7:0] bits);
        @(negedge clk);
        evt_cmd_i = bits;
        @(negedge clk);
        evt_cmd_i = '0;
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        chk_reg("R1 status A", ADR_STAT_A, 8'h00);
        chk_reg("R1 status B", ADR_STAT_B, 8'h00);
        chk_reg("R1 mask A", ADR_MASK_A, 8'h00);
        chk_reg("R1 mask B", ADR_MASK_B, 8'h00);
        chk_reg("R1 cfg lo", ADR_CFG_LO, 8'h00);
        chk_reg("R1 cfg hi", ADR_CFG_HI, 8'h00);
        check("R1 irq", irq_o, 1'b0);
        check("R1 blk len", blk_len_m1_o, 11'h000);
        check("R1 crc abort", crc_abort_o, 1'b0);

        // R10 configuration word
        wr(ADR_CFG_LO, 8'h23);
        wr(ADR_CFG_HI, 8'h8D);
        chk_reg("R10 cfg lo", ADR_CFG_LO, 8'h23);
        chk_reg("R10 cfg hi", ADR_CFG_HI, 8'h8D);
        check("R10 blk len", blk_len_m1_o, 11'h523);
        check("R10 crc abort", crc_abort_o, 1'b1);

        // R5 / R6 status A events and mask A
        wr(ADR_MASK_A, 8'hFF);
        chk_reg("R6 mask A implemented bits", ADR_MASK_A, 8'hF0);
        @(negedge clk); evt_mblk_done_i = 1'b1;
        @(negedge clk); evt_mblk_done_i = 1'b0;
        chk_reg("R5 multi-block bit", ADR_STAT_A, 8'h10);
        check("R6 irq from status A", irq_o, 1'b1);
        @(negedge clk); evt_blk_done_i = 1'b1;
        @(negedge clk); evt_blk_done_i = 1'b0;
        chk_reg("R5 block bit", ADR_STAT_A, 8'h30);
        wr(ADR_STAT_A, 8'h10);
        chk_reg("R3 partial clear A", ADR_STAT_A, 8'h20);
        wr(ADR_STAT_A, 8'hFF);
        chk_reg("R3 full clear A", ADR_STAT_A, 8'h00);
        check("R6 irq after clear", irq_o, 1'b0);

        // R2 R3 R4 R6 table walk on status B
        wr(ADR_MASK_B, 8'hFF);
        chk_reg("R6 mask B implemented bits", ADR_MASK_B, 8'hFE);
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            evt_cmd_i = VECS[i].ev;
            if (VECS[i].wr) begin
                reg_wr_i = 1'b1; reg_addr_i = ADR_STAT_B; reg_wdata_i = VECS[i].wdata;
            end
            @(negedge clk);
            evt_cmd_i = '0; reg_wr_i = 1'b0; reg_addr_i = ADR_STAT_B;
            #1;
            check($sformatf("R2 R3 R4 vec%0d status B", i), reg_rdata_o, VECS[i].exp_b);
            check($sformatf("R6 vec%0d irq", i), irq_o, VECS[i].exp_irq);
        end

        // R6 global enable gating
        pulse_b(8'h02);
        idle(1);
        check("R6 irq with enable", irq_o, 1'b1);
        wr(ADR_CFG_HI, 8'h0D);
        idle(1);
        check("R6 irq gated off", irq_o, 1'b0);
        wr(ADR_CFG_HI, 8'h8D);
        idle(1);
        check("R6 irq gated on again", irq_o, 1'b1);
        wr(ADR_STAT_B, 8'hFF);

        // R8 live pin levels (no detect source selected)
        @(negedge clk); pin_wp_i = 1'b1;
        idle(4);
        chk_reg("R8 write protect level", ADR_STAT_A, 8'h02);
        wr(ADR_STAT_A, 8'hFF);
        chk_reg("R8 level ignores clear", ADR_STAT_A, 8'h02);
        @(negedge clk); pin_dat3_i = 1'b1; pin_gpi_i = 1'b1;
        idle(4);
        chk_reg("R8 R9 all levels, no source no events", ADR_STAT_A, 8'h0E);
        @(negedge clk); pin_wp_i = 1'b0; pin_dat3_i = 1'b0; pin_gpi_i = 1'b0;
        idle(4);
        chk_reg("R8 levels low", ADR_STAT_A, 8'h00);

        // R9 detect pin, active high
        wr(ADR_CFG_HI, 8'hB5);
        idle(3);
        wr(ADR_STAT_A, 8'hFF);
        chk_reg("R9 quiet after select", ADR_STAT_A, 8'h00);
        @(negedge clk); pin_gpi_i = 1'b1;
        idle(4);
        chk_reg("R9 insertion active high", ADR_STAT_A, 8'hC8);
        check("R9 irq on insertion", irq_o, 1'b1);
        wr(ADR_STAT_A, 8'hC0);
        @(negedge clk); pin_gpi_i = 1'b0;
        idle(4);
        chk_reg("R9 removal sets change only", ADR_STAT_A, 8'h40);
        wr(ADR_STAT_A, 8'hFF);

        // R9 active low: rewriting polarity is not an event
        wr(ADR_CFG_HI, 8'hA5);
        idle(3);
        chk_reg("R9 polarity rewrite no event", ADR_STAT_A, 8'h00);
        @(negedge clk); pin_gpi_i = 1'b1;
        idle(4);
        chk_reg("R9 active low removal", ADR_STAT_A, 8'h48);
        wr(ADR_STAT_A, 8'h40);
        @(negedge clk); pin_gpi_i = 1'b0;
        idle(4);
        chk_reg("R9 active low insertion", ADR_STAT_A, 8'hC0);
        wr(ADR_STAT_A, 8'hFF);

        // R9 DAT3 wins when both selected
        wr(ADR_CFG_HI, 8'hF5);
        idle(3);
        wr(ADR_STAT_A, 8'hFF);
        @(negedge clk); pin_gpi_i = 1'b1;
        idle(4);
        chk_reg("R9 detect pin ignored when DAT3 selected", ADR_STAT_A, 8'h08);
        @(negedge clk); pin_dat3_i = 1'b1;
        idle(4);
        chk_reg("R9 DAT3 insertion", ADR_STAT_A, 8'hCC);
        @(negedge clk); pin_dat3_i = 1'b0; pin_gpi_i = 1'b0;
        idle(4);
        wr(ADR_CFG_HI, 8'h85);
        idle(3);
        wr(ADR_STAT_A, 8'hFF);
        chk_reg("R3 cleared after DAT3 test", ADR_STAT_A, 8'h00);

        // R9 no source selected
        @(negedge clk); pin_gpi_i = 1'b1;
        idle(4);
        chk_reg("R9 no source no event", ADR_STAT_A, 8'h08);
        @(negedge clk); pin_gpi_i = 1'b0;
        idle(4);

        // R7 soft reset
        wr(ADR_MASK_B, 8'h02);
        wr(ADR_CTRL, 8'h7F);
        chk_reg("R7 control without bit 7 keeps mask", ADR_MASK_B, 8'h02);
        pulse_b(8'h06);
        @(negedge clk); evt_mblk_done_i = 1'b1;
        @(negedge clk); evt_mblk_done_i = 1'b0;
        idle(1);
        check("R7 irq before soft reset", irq_o, 1'b1);
        @(negedge clk);
        reg_wr_i = 1'b1; reg_addr_i = ADR_CTRL; reg_wdata_i = 8'h80; evt_cmd_i = 8'h10;
        @(negedge clk);
        reg_wr_i = 1'b0; evt_cmd_i = '0;
        chk_reg("R7 status B cleared", ADR_STAT_B, 8'h00);
        chk_reg("R7 status A cleared", ADR_STAT_A, 8'h00);
        chk_reg("R7 mask A cleared", ADR_MASK_A, 8'h00);
        chk_reg("R7 mask B cleared", ADR_MASK_B, 8'h00);
        chk_reg("R7 cfg lo kept", ADR_CFG_LO, 8'h23);
        chk_reg("R7 cfg hi kept", ADR_CFG_HI, 8'h85);
        check("R7 irq low", irq_o, 1'b0);
        check("R7 blk len kept", blk_len_m1_o, 11'h523);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule